// File: doc/BRIEF.md
# ADC Mode Sequencer Controller

This block holds the 8-bit operating-mode register of an analog-to-digital conversion subsystem and runs the finite-state controller that sequences the converters. Software writes the register to pick a clock rate, a power configuration, a low-power reference option and an operating mode. The controller then waits for the next conversion-clock strobe and issues a start pulse to the converters. It counts the settle period of two or three conversion-clock strobes and captures the settled sample of every enabled channel.

Where a captured sample goes depends on the mode. A conversion writes it to a data register, but only while the ready flag is clear. A self-offset or system zero-scale calibration writes it to an offset register, and a system full-scale calibration writes it to a gain register. Single conversions and all calibrations rewrite the mode field to idle on their own when they finish. Continuous mode restarts at once and stays in that mode. Writing the register during an operation abandons the operation silently, and the new mode begins on the next strobe.

Top module: `adc_mode_seq`

## Requirements
- R1: After reset the register reads 0x00, the converters are unpowered and not held in reset, ready and calibration-done are low, the data and offset registers are zero and each gain register holds GAIN_INIT (top bit set).
- R2: The register fields are: bit 7 fast conversion clock, bit 6 low-power reference select, bits 4:3 power configuration and bits 2:0 mode. Bit 5 ignores writes and reads 0. Every other bit reads back as written.
- R3: Power configuration 01 and 11 drive the low-power output, and 11 also drives the amplifier-off output. Configurations 00 and 10 give normal mode. The high-power reference output equals bit 6 only while the low-power output is high.
- R4: Mode 000 removes converter power. Modes 011 and reserved 101 keep power on with the converters held in reset. Code 101 reads back as 101. No start pulse is issued in these three modes.
- R5: In modes 001, 010, 100, 110 and 111, the start pulse comes on the first conversion-clock strobe after the write. The sample is captured on the strobe that comes 3 strobes after the start strobe when chop is enabled, and 2 strobes after it when chop is disabled. Ready stays low until that strobe.
- R6: Single mode (010) writes the captured sample into the data register of each enabled channel and leaves disabled channels unchanged. It sets ready, rewrites the mode field to 011 and issues no further start.
- R7: Self-offset calibration (100) selects the internal zero input while active. It writes the sample into the offset registers of the enabled channels, sets calibration-done and ready, leaves the data registers untouched and rewrites the mode field to 011.
- R8: System zero-scale calibration (110) writes the offset registers, and system full-scale calibration (111) writes the gain registers. Neither one selects the internal zero input. Both set calibration-done and ready and rewrite the mode field to 011.
- R9: Continuous mode (001) issues a new start on every capture strobe and sets ready after each capture. The mode field stays at 001.
- R10: A captured conversion sample is not written to a data register while ready is set. The status-clear input clears both ready and calibration-done.
- R11: A register write during an armed or running operation abandons it without any status or register update. The newly written mode starts on the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| stat_clr | input | 1 | Clears ready and calibration-done |
| conv_tick | input | 1 | One-cycle strobe per conversion-clock period |
| chop_en | input | 1 | Chop enabled: 3-strobe settle instead of 2 |
| chan_en | input | NCH | Per-channel converter enable |
| cnv_sample | input | NCH*DW | Per-channel converter samples |
| cnv_start | output | 1 | Conversion start pulse, aligned to a strobe |
| cnv_settle | output | CNT_W | Settle count in use |
| zero_in_sel | output | 1 | Converter input switched to internal zero |
| conv_fast_clk | output | 1 | Fast conversion clock selected |
| lp_mode | output | 1 | Low-power mode active |
| pga_off | output | 1 | Input amplifier switched off |
| ref_hp | output | 1 | High-power reference in low-power mode |
| conv_pwr_on | output | 1 | Converters and amplifier powered |
| conv_hold_rst | output | 1 | Converters powered but held in reset |
| rdy | output | 1 | Conversion ready flag |
| cal_done | output | 1 | Calibration done flag |
| data_out | output | NCH*DW | Data registers |
| offset_out | output | NCH*DW | Offset registers |
| gain_out | output | NCH*DW | Gain registers |

## Verification
A sequencer stuck in the wrong state shows at the ports as a missing or extra start pulse on the very strobe where the bench samples it, or as ready rising one strobe early or late. An off-by-one in the settle counter makes the wrong ramp sample land in a result register, because every strobe presents a distinct value. A wrong capture destination or a broken ready gate shows up on the first compare of the data, offset or gain buses after the capture strobe. A missed self-return to idle shows in the low mode bits at that same sample.

// File: rtl/adc_mode_seq_pkg.sv
`timescale 1ns/1ps
package adc_mode_seq_pkg;

   typedef enum logic [2:0] {
      MD_PWRDN  = 3'b000,
      MD_CONT   = 3'b001,
      MD_SINGLE = 3'b010,
      MD_IDLE   = 3'b011,
      MD_OFFCAL = 3'b100,
      MD_RSVD   = 3'b101,
      MD_ZSCAL  = 3'b110,
      MD_FSCAL  = 3'b111
   } op_mode_e;

   typedef enum logic [1:0] {
      ST_OFF,
      ST_IDLE,
      ST_ARM,
      ST_RUN
   } seq_state_e;

   typedef enum logic [1:0] {
      DST_NONE,
      DST_DATA,
      DST_OFFSET,
      DST_GAIN
   } dest_e;

   // where a settled sample is routed in a given mode
   function automatic dest_e mode_dest(op_mode_e m);
      case (m)
         MD_CONT, MD_SINGLE:  return DST_DATA;
         MD_OFFCAL, MD_ZSCAL: return DST_OFFSET;
         MD_FSCAL:            return DST_GAIN;
         default:             return DST_NONE;
      endcase
   endfunction

   // state taken right after a register write
   function automatic seq_state_e entry_state(op_mode_e m);
      case (m)
         MD_PWRDN:         return ST_OFF;
         MD_IDLE, MD_RSVD: return ST_IDLE;
         default:          return ST_ARM;
      endcase
   endfunction

endpackage

// File: rtl/adc_mode_seq_reg.sv
`timescale 1ns/1ps
module adc_mode_seq_reg
   import adc_mode_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       idle_req,
   output logic [7:0] rd_data,
   output op_mode_e   mode_o,
   output logic       fast_clk,
   output logic       lp_mode,
   output logic       pga_off,
   output logic       ref_hp
);

   logic       clk_sel_q;
   logic       ref_sel_q;
   logic [1:0] pcfg_q;
   logic [2:0] mode_q;
   logic       rsvd_unused;

   assign rsvd_unused = wr_data[5];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_sel_q <= 1'b0;
         ref_sel_q <= 1'b0;
         pcfg_q    <= 2'b00;
         mode_q    <= MD_PWRDN;
      end else if (wr_en) begin
         clk_sel_q <= wr_data[7];
         ref_sel_q <= wr_data[6];
         pcfg_q    <= wr_data[4:3];
         mode_q    <= wr_data[2:0];
      end else if (idle_req) begin
         mode_q    <= MD_IDLE;
      end
   end

   assign rd_data  = {clk_sel_q, ref_sel_q, 1'b0, pcfg_q, mode_q};
   assign mode_o   = op_mode_e'(mode_q);
   assign fast_clk = clk_sel_q;

   always_comb begin
      lp_mode = 1'b0;
      pga_off = 1'b0;
      case (pcfg_q)
         2'b01:   lp_mode = 1'b1;
         2'b11: begin
            lp_mode = 1'b1;
            pga_off = 1'b1;
         end
         default: lp_mode = 1'b0;
      endcase
   end

   assign ref_hp = ref_sel_q & lp_mode;

   assert_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en) |-> (rd_data[7:6] == $past(wr_data[7:6]) && rd_data[4:0] == $past(wr_data[4:0])));

endmodule

// File: rtl/adc_mode_seq_fsm.sv
`timescale 1ns/1ps
module adc_mode_seq_fsm
   import adc_mode_seq_pkg::*;
#(
   parameter int SETTLE_CHOP  = 3,
   parameter int SETTLE_PLAIN = 2,
   parameter int CNT_W        = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  op_mode_e         wr_mode,
   input  op_mode_e         mode_i,
   input  logic             conv_tick,
   input  logic             chop_en,
   input  logic             stat_clr,
   output logic             cnv_start,
   output logic [CNT_W-1:0] settle_o,
   output logic             data_we,
   output logic             off_we,
   output logic             gain_we,
   output logic             idle_req,
   output logic             rdy_o,
   output logic             cal_done_o,
   output logic             pwr_on,
   output logic             hold_rst,
   output logic             zero_sel
);

   seq_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] settle_q;
   logic [CNT_W-1:0] settle_now;
   logic             rdy_q;
   logic             cal_q;
   logic             launch;
   logic             done_tick;
   dest_e            dest;

   assign settle_now = chop_en ? CNT_W'(SETTLE_CHOP) : CNT_W'(SETTLE_PLAIN);
   assign cnt_nxt    = cnt_q + CNT_W'(1);
   assign dest       = mode_dest(mode_i);

   // a write in the same cycle always wins over a strobe
   assign launch    = conv_tick && !wr_en && (state_q == ST_ARM);
   assign done_tick = conv_tick && !wr_en && (state_q == ST_RUN) && (cnt_nxt == settle_q);

   assign cnv_start = launch || (done_tick && (mode_i == MD_CONT));
   assign idle_req  = done_tick && (mode_i != MD_CONT);
   assign data_we   = done_tick && (dest == DST_DATA) && !rdy_q;
   assign off_we    = done_tick && (dest == DST_OFFSET);
   assign gain_we   = done_tick && (dest == DST_GAIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_OFF;
         cnt_q    <= '0;
         settle_q <= CNT_W'(SETTLE_PLAIN);
      end else if (wr_en) begin
         state_q  <= entry_state(wr_mode);
         cnt_q    <= '0;
      end else if (launch) begin
         state_q  <= ST_RUN;
         cnt_q    <= '0;
         settle_q <= settle_now;
      end else if (done_tick) begin
         cnt_q <= '0;
         if (mode_i == MD_CONT) begin
            settle_q <= settle_now;
         end else begin
            state_q  <= ST_IDLE;
         end
      end else if (conv_tick && (state_q == ST_RUN)) begin
         cnt_q <= cnt_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q <= 1'b0;
         cal_q <= 1'b0;
      end else if (done_tick) begin
         rdy_q <= 1'b1;
         if (dest != DST_DATA) begin
            cal_q <= 1'b1;
         end
      end else if (stat_clr) begin
         rdy_q <= 1'b0;
         cal_q <= 1'b0;
      end
   end

   assign settle_o   = settle_q;
   assign rdy_o      = rdy_q;
   assign cal_done_o = cal_q;
   assign pwr_on     = (state_q != ST_OFF);
   assign hold_rst   = (state_q == ST_IDLE);
   assign zero_sel   = ((state_q == ST_ARM) || (state_q == ST_RUN)) && (mode_i == MD_OFFCAL);

   assert_cal_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_q) |-> (mode_i == MD_IDLE));

   assert_single_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == ST_RUN && state_q == ST_IDLE && !$past(wr_en)) |-> (mode_i == MD_IDLE));

   assert_cal_rdy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cal_q |-> rdy_q);

   assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en) |-> !$rose(rdy_q));

   assert_off_nostart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OFF || state_q == ST_IDLE) |-> !cnv_start);

endmodule

// File: rtl/adc_mode_seq_chan.sv
`timescale 1ns/1ps
module adc_mode_seq_chan #(
   parameter int            DW        = 24,
   parameter logic [DW-1:0] GAIN_INIT = '0
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          data_we,
   input  logic          off_we,
   input  logic          gain_we,
   input  logic [DW-1:0] sample,
   output logic [DW-1:0] data_q,
   output logic [DW-1:0] off_q,
   output logic [DW-1:0] gain_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         off_q  <= '0;
         gain_q <= GAIN_INIT;
      end else if (sel) begin
         if (data_we) data_q <= sample;
         if (off_we)  off_q  <= sample;
         if (gain_we) gain_q <= sample;
      end
   end

   assert_onedest_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({!$stable(data_q), !$stable(off_q), !$stable(gain_q)}) <= 1);

endmodule

// File: rtl/adc_mode_seq.sv
`timescale 1ns/1ps
module adc_mode_seq
   import adc_mode_seq_pkg::*;
#(
   parameter int            NCH          = 2,
   parameter int            DW           = 24,
   parameter int            SETTLE_CHOP  = 3,
   parameter int            SETTLE_PLAIN = 2,
   parameter logic [DW-1:0] GAIN_INIT    = {1'b1, {(DW-1){1'b0}}},
   parameter int            CNT_W        = $clog2(((SETTLE_CHOP > SETTLE_PLAIN) ? SETTLE_CHOP : SETTLE_PLAIN) + 1)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [7:0]         reg_wdata,
   output logic [7:0]         reg_rdata,
   input  logic               stat_clr,
   input  logic               conv_tick,
   input  logic               chop_en,
   input  logic [NCH-1:0]     chan_en,
   input  logic [NCH*DW-1:0]  cnv_sample,
   output logic               cnv_start,
   output logic [CNT_W-1:0]   cnv_settle,
   output logic               zero_in_sel,
   output logic               conv_fast_clk,
   output logic               lp_mode,
   output logic               pga_off,
   output logic               ref_hp,
   output logic               conv_pwr_on,
   output logic               conv_hold_rst,
   output logic               rdy,
   output logic               cal_done,
   output logic [NCH*DW-1:0]  data_out,
   output logic [NCH*DW-1:0]  offset_out,
   output logic [NCH*DW-1:0]  gain_out
);

   localparam int SETTLE_MAX = (SETTLE_CHOP > SETTLE_PLAIN) ? SETTLE_CHOP : SETTLE_PLAIN;

   if (NCH < 1 || NCH > 16) begin : g_bad_nch
      $error("NCH must be between 1 and 16");
   end
   if (DW < 2) begin : g_bad_dw
      $error("DW must be at least 2");
   end
   if (SETTLE_PLAIN < 1) begin : g_bad_settle
      $error("settle counts must be at least 1");
   end
   if ((1 << CNT_W) <= SETTLE_MAX) begin : g_bad_cntw
      $error("CNT_W too narrow for the settle count");
   end

   op_mode_e mode;
   logic     idle_req;
   logic     data_we;
   logic     off_we;
   logic     gain_we;

   adc_mode_seq_reg u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .wr_data  (reg_wdata),
      .idle_req (idle_req),
      .rd_data  (reg_rdata),
      .mode_o   (mode),
      .fast_clk (conv_fast_clk),
      .lp_mode  (lp_mode),
      .pga_off  (pga_off),
      .ref_hp   (ref_hp)
   );

   adc_mode_seq_fsm #(
      .SETTLE_CHOP  (SETTLE_CHOP),
      .SETTLE_PLAIN (SETTLE_PLAIN),
      .CNT_W        (CNT_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr),
      .wr_mode    (op_mode_e'(reg_wdata[2:0])),
      .mode_i     (mode),
      .conv_tick  (conv_tick),
      .chop_en    (chop_en),
      .stat_clr   (stat_clr),
      .cnv_start  (cnv_start),
      .settle_o   (cnv_settle),
      .data_we    (data_we),
      .off_we     (off_we),
      .gain_we    (gain_we),
      .idle_req   (idle_req),
      .rdy_o      (rdy),
      .cal_done_o (cal_done),
      .pwr_on     (conv_pwr_on),
      .hold_rst   (conv_hold_rst),
      .zero_sel   (zero_in_sel)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      adc_mode_seq_chan #(
         .DW        (DW),
         .GAIN_INIT (GAIN_INIT)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .sel     (chan_en[c]),
         .data_we (data_we),
         .off_we  (off_we),
         .gain_we (gain_we),
         .sample  (cnv_sample[c*DW +: DW]),
         .data_q  (data_out[c*DW +: DW]),
         .off_q   (offset_out[c*DW +: DW]),
         .gain_q  (gain_out[c*DW +: DW])
      );
   end

   assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_out) |-> !$past(rdy));

   assert_start_power_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_start |-> (conv_pwr_on && !conv_hold_rst));

endmodule

// File: tb/adc_mode_seq_bench.sv
`timescale 1ns/1ps
module adc_mode_seq_bench;
   localparam int NCH = 2;
   localparam int DW  = 24;
   localparam int CW  = 2;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic              rst_n, reg_wr, stat_clr, conv_tick, chop_en;
   logic [7:0]        reg_wdata, reg_rdata;
   logic [NCH-1:0]    chan_en;
   logic [NCH*DW-1:0] cnv_sample, data_out, offset_out, gain_out;
   logic              cnv_start, zero_in_sel, conv_fast_clk, lp_mode, pga_off, ref_hp;
   logic              conv_pwr_on, conv_hold_rst, rdy, cal_done;
   logic [CW-1:0]     cnv_settle;

   adc_mode_seq u_adc_mode_seq (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .stat_clr(stat_clr), .conv_tick(conv_tick), .chop_en(chop_en), .chan_en(chan_en),
      .cnv_sample(cnv_sample), .cnv_start(cnv_start), .cnv_settle(cnv_settle),
      .zero_in_sel(zero_in_sel), .conv_fast_clk(conv_fast_clk), .lp_mode(lp_mode),
      .pga_off(pga_off), .ref_hp(ref_hp), .conv_pwr_on(conv_pwr_on),
      .conv_hold_rst(conv_hold_rst), .rdy(rdy), .cal_done(cal_done),
      .data_out(data_out), .offset_out(offset_out), .gain_out(gain_out)
   );

   int nvec = 0;
   int nbad = 0;
   int tk   = 0;
   logic last_start;
   logic [DW-1:0] e_data [NCH];
   logic [DW-1:0] e_off  [NCH];
   logic [DW-1:0] e_gain [NCH];

   function automatic logic [DW-1:0] smp(int ch, int t);
      return DW'(t * 291 + ch * 65536 + 5);
   endfunction

   function automatic logic [NCH*DW-1:0] pk(int which);
      logic [NCH*DW-1:0] r;
      for (int c = 0; c < NCH; c++) begin
         r[c*DW +: DW] = (which == 0) ? e_data[c] : (which == 1) ? e_off[c] : e_gain[c];
      end
      return r;
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] v);
      reg_wr = 1'b1; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic clr();
      stat_clr = 1'b1;
      @(negedge clk);
      stat_clr = 1'b0;
   endtask

   task automatic tick();
      tk++;
      for (int c = 0; c < NCH; c++) cnv_sample[c*DW +: DW] = smp(c, tk);
      conv_tick = 1'b1;
      #1 last_start = cnv_start;
      @(negedge clk);
      conv_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic check_regs(string req);
      chk({req, " data"},   64'(data_out),   64'(pk(0)));
      chk({req, " offset"}, 64'(offset_out), 64'(pk(1)));
      chk({req, " gain"},   64'(gain_out),   64'(pk(2)));
   endtask

   task automatic run_op(logic [2:0] md, logic chop, logic [NCH-1:0] en);
      int st;
      string tg;
      st = chop ? 3 : 2;
      tg = (md == 3'b010) ? "R6" : (md == 3'b100) ? "R7" : "R8";
      chop_en = chop; chan_en = en;
      clr();
      wr({5'b10001, md});
      tick();
      chk("R5 start on first strobe", 64'(last_start), 64'd1);
      chk({tg, " zero input select"}, 64'(zero_in_sel), 64'(md == 3'b100));
      for (int i = 1; i < st; i++) tick();
      chk("R5 no capture before settle", 64'(rdy), 64'd0);
      tick();
      for (int c = 0; c < NCH; c++) begin
         if (en[c]) begin
            if (md == 3'b010) e_data[c] = smp(c, tk);
            else if (md == 3'b111) e_gain[c] = smp(c, tk);
            else e_off[c] = smp(c, tk);
         end
      end
      check_regs(tg);
      chk({tg, " ready"}, 64'(rdy), 64'd1);
      chk({tg, " cal done"}, 64'(cal_done), 64'(md != 3'b010));
      chk({tg, " mode back to idle"}, 64'(reg_rdata), 64'h8B);
      tick();
      chk({tg, " no restart"}, 64'(last_start), 64'd0);
   endtask

   initial begin
      #(5.0 * 150000);
      nbad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      int t3;
      rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; stat_clr = 1'b0;
      conv_tick = 1'b0; chop_en = 1'b0; chan_en = '0; cnv_sample = '0;
      for (int c = 0; c < NCH; c++) begin
         e_data[c] = '0; e_off[c] = '0; e_gain[c] = {1'b1, {(DW-1){1'b0}}};
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 register", 64'(reg_rdata), 64'h00);
      chk("R1 power", 64'(conv_pwr_on), 64'd0);
      chk("R1 hold", 64'(conv_hold_rst), 64'd0);
      chk("R1 status", 64'({rdy, cal_done}), 64'd0);
      check_regs("R1");

      // R2, R3: sweep bits 7:3 with mode idle
      for (int v = 0; v < 32; v++) begin
         logic [7:0] w;
         logic lp;
         w = {v[4:0], 3'b011};
         wr(w);
         lp = v[0];
         chk("R2 readback", 64'(reg_rdata), 64'(w & 8'hDF));
         chk("R2 fast clock", 64'(conv_fast_clk), 64'(v[4]));
         chk("R3 low power", 64'(lp_mode), 64'(lp));
         chk("R3 amplifier off", 64'(pga_off), 64'(v[1:0] == 2'b11));
         chk("R3 reference", 64'(ref_hp), 64'(v[3] & lp));
         chk("R4 idle hold", 64'({conv_pwr_on, conv_hold_rst}), 64'b11);
      end

      // R5..R8 sweep of one-shot modes
      for (int ch = 0; ch < 2; ch++) begin
         for (int en = 1; en < 4; en++) begin
            run_op(3'b010, ch[0], NCH'(en));
            run_op(3'b100, ch[0], NCH'(en));
            run_op(3'b110, ch[0], NCH'(en));
            run_op(3'b111, ch[0], NCH'(en));
         end
      end

      // R9, R10 continuous mode with ready gating
      chop_en = 1'b0; chan_en = 2'b11;
      clr();
      wr(8'h01);
      tick();
      chk("R9 first start", 64'(last_start), 64'd1);
      tick(); tick();
      t3 = tk;
      chk("R9 restart on capture", 64'(last_start), 64'd1);
      for (int c = 0; c < NCH; c++) e_data[c] = smp(c, t3);
      check_regs("R9");
      chk("R9 ready", 64'(rdy), 64'd1);
      tick(); tick();
      chk("R9 second restart", 64'(last_start), 64'd1);
      check_regs("R10 blocked while ready");
      chk("R9 mode stays", 64'(reg_rdata), 64'h01);
      clr();
      chk("R10 clear", 64'({rdy, cal_done}), 64'd0);
      tick(); tick();
      for (int c = 0; c < NCH; c++) e_data[c] = smp(c, tk);
      check_regs("R10 after clear");
      chk("R9 ready again", 64'(rdy), 64'd1);
      wr(8'h03);
      clr();

      // R11 abort to idle
      wr(8'h02);
      tick(); tick();
      wr(8'h03);
      tick(); tick(); tick();
      chk("R11 no start in idle", 64'(last_start), 64'd0);
      chk("R11 no status", 64'({rdy, cal_done}), 64'd0);
      chk("R11 mode kept", 64'(reg_rdata), 64'h03);
      check_regs("R11 abort");

      // R11 abort into a new active mode
      wr(8'h04);
      tick();
      wr(8'h02);
      tick();
      chk("R11 new mode start", 64'(last_start), 64'd1);
      tick(); tick();
      for (int c = 0; c < NCH; c++) e_data[c] = smp(c, tk);
      check_regs("R11 new mode");
      chk("R11 status", 64'({rdy, cal_done}), 64'b10);

      // R4 reserved code and power-down
      wr(8'h05);
      chk("R4 reserved readback", 64'(reg_rdata), 64'h05);
      chk("R4 reserved hold", 64'({conv_pwr_on, conv_hold_rst}), 64'b11);
      tick();
      chk("R4 reserved no start", 64'(last_start), 64'd0);
      wr(8'h00);
      chk("R4 power down", 64'({conv_pwr_on, conv_hold_rst}), 64'b00);
      tick();
      chk("R4 power down no start", 64'(last_start), 64'd0);
      check_regs("R4");

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule